// File: doc/BRIEF.md
# Mode-Dependent Software Watchdog Timer

This block is the software watchdog that a device mode controller consults. It counts ticks from the last accepted refresh command. When the count reaches the period in force for the current operating mode and no refresh has arrived, it emits a single-cycle fault pulse, and the mode controller uses that pulse to send the device to reset. A refresh command marked as malformed also produces a fault at once. In the extended-period programming mode the watchdog also emits a single-cycle early-warning interrupt when half of the period has elapsed.

The mode controller gives the block the current mode code, a 2-bit period-select field and a debug flag, and passes on each decoded refresh command as a strobe with a validity flag. In normal mode the period comes from a four-entry table that the select field indexes. In flash mode a single, much longer period applies. In every other mode, and whenever debug is active, the counter is held at zero and the block stays quiet. Any change of mode restarts the count.

Top module: `wdog_timer`

## Requirements
- R1: After reset, faultPulse and irqPulse are low, and the tick count is zero.
- R2: modeCode 3'd2 is normal mode and 3'd4 is flash mode. With any other code the count is held at zero, ticks have no effect and no pulse is produced.
- R3: In normal mode, periodSel values 0..3 select PER_SEL0..PER_SEL3 ticks. faultPulse goes high in the cycle after the tick that brings the count to the selected period.
- R4: In flash mode the period is FLASH_PERIOD ticks and periodSel is ignored. The fault follows the same timing as in R3.
- R5: In flash mode irqPulse goes high in the cycle after the tick that brings the count to floor(FLASH_PERIOD/2). No interrupt is ever produced in normal mode.
- R6: A refresh strobe with refreshOk=1 clears the count and rearms both the fault and the interrupt. If a tick arrives in the same cycle, the refresh takes precedence.
- R7: A refresh strobe with refreshOk=0 in normal or flash mode raises faultPulse in the next cycle and leaves the count unchanged.
- R8: After an expiry the count stops. No further expiry fault occurs until a good refresh or a mode change.
- R9: While debugOn is high the count is held at zero and neither faultPulse nor irqPulse is raised, even for a malformed refresh.
- R10: A change of modeCode restarts the count from zero and rearms the fault and the interrupt.
- R11: Each expiry fault and each interrupt is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickIn | input | 1 | Time-base tick, one cycle wide |
| refreshStb | input | 1 | Decoded refresh command strobe |
| refreshOk | input | 1 | Refresh command well formed (valid with the strobe) |
| modeCode | input | 3 | Current device mode code |
| periodSel | input | 2 | Normal-mode period table index |
| debugOn | input | 1 | Debug active; disables the watchdog |
| faultPulse | output | 1 | Watchdog fault pulse |
| irqPulse | output | 1 | Half-period interrupt pulse |

## Verification
A vector table starts each case from a fresh mode entry and applies a run of ticks that ends either one tick short of the boundary, exactly on it, or well past it. Every table entry and every flash case is tried this way. The short and exact runs fix the expiry and half-period points to a single tick. The long runs separate a one-time fault from a repeating one. The same runs in idle codes and in normal mode separate a watchdog that is truly gated by mode from one that counts everywhere. Directed cases then place refreshes mid-period, coincident with a tick and malformed, and toggle debug and the mode code, so that each source of restart and each source of fault is exercised on its own.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_NORMAL = 3'd2;
  localparam logic [MODE_W-1:0] MODE_FLASH  = 3'd4;
  localparam int SEL_W = 2;
  localparam int NUM_SEL = 1 << SEL_W;

  typedef struct packed {
    logic clr;
    logic inc;
  } wdStrb_t;
endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int unsigned PER_SEL0     = 32,
  parameter int unsigned PER_SEL1     = 64,
  parameter int unsigned PER_SEL2     = 128,
  parameter int unsigned PER_SEL3     = 256,
  parameter int unsigned FLASH_PERIOD = 32768,
  parameter int          CNT_W        = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdStrb_t          strb,
  input  logic             flashSel,
  input  logic [SEL_W-1:0] periodSel,
  output logic [CNT_W-1:0] cnt,
  output logic             hitFull,
  output logic             hitHalf
);
  logic [CNT_W-1:0] selTable [NUM_SEL];
  logic [CNT_W-1:0] periodVal;
  logic [CNT_W-1:0] halfVal;
  logic [CNT_W-1:0] nextCnt;

  generate
    for (genvar g = 0; g < NUM_SEL; g++) begin : gTable
      localparam int unsigned ENTRY = (g == 0) ? PER_SEL0 :
                                      (g == 1) ? PER_SEL1 :
                                      (g == 2) ? PER_SEL2 : PER_SEL3;
      assign selTable[g] = CNT_W'(ENTRY);
    end
  endgenerate

  assign periodVal = flashSel ? CNT_W'(FLASH_PERIOD) : selTable[periodSel];
  assign halfVal   = periodVal >> 1;
  assign nextCnt   = cnt + 1'b1;
  assign hitFull   = (nextCnt >= periodVal);
  assign hitHalf   = (nextCnt == halfVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         cnt <= '0;
    else if (strb.clr) cnt <= '0;
    else if (strb.inc) cnt <= nextCnt;
  end

  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.inc && !strb.clr) |=> (cnt == $past(cnt) + 1'b1)); // R3
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> (cnt == '0)); // R6
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic              refreshStb,
  input  logic              refreshOk,
  input  logic [MODE_W-1:0] modeCode,
  input  logic              debugOn,
  input  logic [CNT_W-1:0]  cntIn,
  input  logic              hitFull,
  input  logic              hitHalf,
  output wdStrb_t           strb,
  output logic              flashSel,
  output logic              faultPulse,
  output logic              irqPulse
);
  logic [MODE_W-1:0] prevMode;
  logic expiredQ, irqDoneQ;
  logic isNorm, active, modeChg, restart, expiry, halfHit, badRef;

  assign isNorm   = (modeCode == MODE_NORMAL);
  assign flashSel = (modeCode == MODE_FLASH);
  assign active   = (isNorm || flashSel) && !debugOn;
  assign modeChg  = (modeCode != prevMode);
  assign restart  = !active || modeChg || (refreshStb && refreshOk);

  always_comb begin
    strb.clr = restart;
    strb.inc = !restart && tickIn && !expiredQ;
  end

  assign expiry  = strb.inc && hitFull;
  assign halfHit = strb.inc && hitHalf && flashSel && !irqDoneQ;
  assign badRef  = active && !modeChg && refreshStb && !refreshOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevMode   <= '0;
      expiredQ   <= 1'b0;
      irqDoneQ   <= 1'b0;
      faultPulse <= 1'b0;
      irqPulse   <= 1'b0;
    end else begin
      prevMode   <= modeCode;
      expiredQ   <= restart ? 1'b0 : (expiredQ || expiry);
      irqDoneQ   <= restart ? 1'b0 : (irqDoneQ || halfHit);
      faultPulse <= expiry || badRef;
      irqPulse   <= halfHit;
    end
  end

  AST_IDLE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> (cntIn == '0)); // R2
  AST_DEBUG_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    debugOn |=> (!faultPulse && !irqPulse)); // R9
  AST_IRQ_FLASH_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> ($past(modeCode) == MODE_FLASH)); // R5
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse); // R11
  AST_STOP_AFTER_EXPIRY: assert property (@(posedge clk) disable iff (!rstN)
    (expiredQ && !restart) |=> $stable(cntIn)); // R8
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned PER_SEL0     = 32,
  parameter int unsigned PER_SEL1     = 64,
  parameter int unsigned PER_SEL2     = 128,
  parameter int unsigned PER_SEL3     = 256,
  parameter int unsigned FLASH_PERIOD = 32768
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickIn,
  input  logic       refreshStb,
  input  logic       refreshOk,
  input  logic [2:0] modeCode,
  input  logic [1:0] periodSel,
  input  logic       debugOn,
  output logic       faultPulse,
  output logic       irqPulse
);
  localparam int unsigned MAX_A = (PER_SEL0 > PER_SEL1) ? PER_SEL0 : PER_SEL1;
  localparam int unsigned MAX_B = (PER_SEL2 > PER_SEL3) ? PER_SEL2 : PER_SEL3;
  localparam int unsigned MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAX_P = (MAX_C > FLASH_PERIOD) ? MAX_C : FLASH_PERIOD;
  localparam int CNT_W = $clog2(MAX_P + 1);

  wdStrb_t          strb;
  logic             flashSel, hitFull, hitHalf;
  logic [CNT_W-1:0] cnt;

  wdog_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .refreshStb(refreshStb),
    .refreshOk(refreshOk), .modeCode(modeCode), .debugOn(debugOn),
    .cntIn(cnt), .hitFull(hitFull), .hitHalf(hitHalf), .strb(strb),
    .flashSel(flashSel), .faultPulse(faultPulse), .irqPulse(irqPulse)
  );

  wdog_datapath #(
    .PER_SEL0(PER_SEL0), .PER_SEL1(PER_SEL1), .PER_SEL2(PER_SEL2),
    .PER_SEL3(PER_SEL3), .FLASH_PERIOD(FLASH_PERIOD), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .flashSel(flashSel),
    .periodSel(periodSel), .cnt(cnt), .hitFull(hitFull), .hitHalf(hitHalf)
  );
endmodule

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;
  localparam logic [2:0] MN = 3'd2, MF = 3'd4, MI = 3'd0;

  logic clk = 1'b0, rstN = 1'b0;
  logic tickIn = 0, refreshStb = 0, refreshOk = 0, debugOn = 0;
  logic [2:0] modeCode = MI;
  logic [1:0] periodSel = 0;
  logic faultPulse, irqPulse;
  int nChecks = 0, nFails = 0, faultSeen = 0, irqSeen = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wdog_timer #(.PER_SEL0(8), .PER_SEL1(16), .PER_SEL2(32), .PER_SEL3(64),
               .FLASH_PERIOD(100)) u_dut (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .refreshStb(refreshStb),
    .refreshOk(refreshOk), .modeCode(modeCode), .periodSel(periodSel),
    .debugOn(debugOn), .faultPulse(faultPulse), .irqPulse(irqPulse)
  );

  always @(negedge clk) begin
    if (faultPulse) faultSeen++;
    if (irqPulse) irqSeen++;
  end

  typedef struct packed {
    logic [2:0] mode;
    logic [1:0] sel;
    logic [7:0] ticks;
    logic [1:0] expF;
    logic [1:0] expI;
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{MN, 2'd0, 8'd7,   2'd0, 2'd0},  // R3 one short
    '{MN, 2'd0, 8'd8,   2'd1, 2'd0},  // R3 exact
    '{MN, 2'd0, 8'd20,  2'd1, 2'd0},  // R8 once only
    '{MN, 2'd1, 8'd15,  2'd0, 2'd0},
    '{MN, 2'd1, 8'd16,  2'd1, 2'd0},
    '{MN, 2'd2, 8'd32,  2'd1, 2'd0},
    '{MN, 2'd3, 8'd63,  2'd0, 2'd0},
    '{MN, 2'd3, 8'd64,  2'd1, 2'd0},
    '{MN, 2'd3, 8'd40,  2'd0, 2'd0},  // R5 none in normal
    '{MF, 2'd0, 8'd49,  2'd0, 2'd0},  // R5 one short of half
    '{MF, 2'd0, 8'd50,  2'd0, 2'd1},  // R5 half
    '{MF, 2'd3, 8'd100, 2'd1, 2'd1},  // R4 sel ignored
    '{MI, 2'd0, 8'd200, 2'd0, 2'd0},  // R2 idle
    '{3'd7, 2'd0, 8'd200, 2'd0, 2'd0} // R2 other code
  };

  task automatic check(input int act, input int exp, input string tag);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 tickIn = 1;
      @(posedge clk); #1 tickIn = 0;
    end
  endtask

  task automatic refresh(input logic ok, input logic withTick);
    @(posedge clk); #1 refreshStb = 1; refreshOk = ok; tickIn = withTick;
    @(posedge clk); #1 refreshStb = 0; refreshOk = 0; tickIn = 0;
  endtask

  task automatic enter(input logic [2:0] m, input logic [1:0] s);
    modeCode = MI; cyc(2);
    modeCode = m; periodSel = s; cyc(2);
  endtask

  int f0, i0;

  initial begin
    cyc(3);
    check(faultPulse, 0, "R1 fault at reset");
    check(irqPulse, 0, "R1 irq at reset");
    rstN = 1; cyc(2);

    foreach (VECS[k]) begin
      enter(VECS[k].mode, VECS[k].sel);
      f0 = faultSeen; i0 = irqSeen;
      ticks(VECS[k].ticks);
      cyc(3);
      check(faultSeen - f0, VECS[k].expF, $sformatf("R3/R4/R8 vec %0d fault", k));
      check(irqSeen - i0, VECS[k].expI, $sformatf("R5 vec %0d irq", k));
    end

    // R6 good refresh mid period
    enter(MN, 0); f0 = faultSeen;
    ticks(6); refresh(1, 0); ticks(7); cyc(3);
    check(faultSeen - f0, 0, "R6 refresh restarts");
    ticks(1); cyc(3);
    check(faultSeen - f0, 1, "R6 expiry after refresh");
    // R8 refresh after expiry rearms
    refresh(1, 0); ticks(8); cyc(3);
    check(faultSeen - f0, 2, "R8 rearmed by refresh");

    // R6 refresh wins over coincident tick
    enter(MN, 0); f0 = faultSeen;
    ticks(7); refresh(1, 1); ticks(7); cyc(3);
    check(faultSeen - f0, 0, "R6 refresh beats tick");
    ticks(1); cyc(3);
    check(faultSeen - f0, 1, "R6 period after coincident refresh");

    // R7 bad refresh immediate, count kept; R11 single cycle
    enter(MN, 0); f0 = faultSeen;
    ticks(3); refresh(0, 0);
    @(negedge clk); check(faultPulse, 1, "R7 bad refresh fault");
    @(negedge clk); check(faultPulse, 0, "R11 fault one cycle");
    ticks(5); cyc(3);
    check(faultSeen - f0, 2, "R7 count unchanged by bad refresh");

    // R6 irq rearmed by refresh
    enter(MF, 0); i0 = irqSeen;
    ticks(50); refresh(1, 0); ticks(50); cyc(3);
    check(irqSeen - i0, 2, "R6 irq rearm");

    // R9 debug
    enter(MN, 0); f0 = faultSeen; i0 = irqSeen;
    debugOn = 1; ticks(20); refresh(0, 0); cyc(3);
    check(faultSeen - f0, 0, "R9 no fault in debug");
    modeCode = MF; cyc(2); ticks(120); cyc(3);
    check(irqSeen - i0, 0, "R9 no irq in debug");
    modeCode = MN; cyc(2);
    debugOn = 0; cyc(2); ticks(7); cyc(3);
    check(faultSeen - f0, 0, "R9 count held during debug");
    ticks(1); cyc(3);
    check(faultSeen - f0, 1, "R9 resumes after debug");

    // R10 mode change restarts
    enter(MN, 0); f0 = faultSeen;
    ticks(5); modeCode = MF; cyc(2); ticks(8); cyc(3);
    check(faultSeen - f0, 0, "R10 flash restart");
    modeCode = MN; cyc(2); ticks(7); cyc(3);
    check(faultSeen - f0, 0, "R10 normal restart");
    ticks(1); cyc(3);
    check(faultSeen - f0, 1, "R10 fault after restart");

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule